// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block holds a single load-linked/store-conditional reservation for a 32-bit core and sits next to its load/store path. On each cycle where the strobe is high, the block takes an instruction word, a base register value and store data. It decodes the major opcode and forms the effective address from the base plus a sign-extended 16-bit immediate. It then decides what the memory side sees: whether a write is issued, the address and the data. It also decides how the shared condition flag changes.

A load-linked access records its effective address as the reserved word. A later store-conditional writes only if the reservation is still live and its address matches exactly. It reports the outcome in the condition flag and always consumes the reservation. An ordinary store (byte, halfword or word) that lands in the reserved word cancels the reservation. All results are registered and appear on the clock edge that samples the strobe.

Top module: `llsc_reserve_unit`

## Requirements
- R1: After reset the condition flag is 0, no write is issued and no reservation is live, so a store-conditional issued first fails.
- R2: A load-linked access (major opcode 0x1B in bits 31:26, immediate in bits 15:0) makes the reservation live and records base + sign-extended immediate as the reserved address. It presents that address on mem_addr and issues no write.
- R3: A store-conditional (major opcode 0x33) whose effective address equals the reserved address while the reservation is live sets the flag to 1. It issues a write of the full 32-bit store data to that address.
- R4: A store-conditional with no live reservation, or with an address different from the reserved one, clears the flag to 0 and issues no write.
- R5: Every store-conditional consumes the reservation, so a second one to the same address fails.
- R6: An ordinary store (0x35 word, 0x36 byte, 0x37 halfword) whose address with bits 1:0 cleared equals the reserved address cancels the reservation. The store itself is still written.
- R7: An ordinary store to a different word is written and leaves the reservation live.
- R8: For all stores the 16-bit immediate is assembled from instruction bits 25:21 (upper five bits) and bits 10:0 (lower eleven bits), then sign-extended.
- R9: Results appear on the clock edge that samples op_valid high. The write enable is a one-cycle pulse. While op_valid is low, no write is issued and the flag and the reservation hold.
- R10: Only a store-conditional changes the condition flag. Load-linked accesses and ordinary stores leave it unchanged.
- R11: A strobed instruction with any other major opcode issues no write and leaves the reservation and the flag untouched.
- R12: A second load-linked access replaces the reserved address, so a store-conditional to the earlier address fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Single-cycle strobe qualifying insn, base_val and store_data |
| insn | input | 32 | Instruction word carrying the opcode and immediate |
| base_val | input | 32 | Base register value |
| store_data | input | 32 | Data for stores |
| mem_we | output | 1 | Memory write enable pulse |
| mem_addr | output | 32 | Effective address of the last recognised access |
| mem_wdata | output | 32 | Write data of the last recognised access |
| cond_flag | output | 1 | Condition flag, result of the last store-conditional |

## Verification
The main function is driven with paired load-linked and store-conditional accesses. Some pairs match, some miss by one word, and some carry a negative immediate. These separate the exact-address compare, the split immediate assembly and the sign extension. Byte, halfword and word stores are placed inside and outside the reserved word. This separates word-granular cancellation from a plain address compare. Repeated store-conditionals, back-to-back reservations, idle cycles holding a conditional opcode, and unrelated opcodes show that the reservation is consumed, replaced, held or ignored as required.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LINK  = 6'h1B;
  localparam logic [OPC_W-1:0] OPC_COND  = 6'h33;
  localparam logic [OPC_W-1:0] OPC_ST_W  = 6'h35;
  localparam logic [OPC_W-1:0] OPC_ST_B  = 6'h36;
  localparam logic [OPC_W-1:0] OPC_ST_H  = 6'h37;

  typedef enum logic [2:0] {
    MOP_NONE,
    MOP_LINK,
    MOP_COND,
    MOP_ST_W,
    MOP_ST_B,
    MOP_ST_H
  } mem_op_e;

endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
  import llsc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 16,
  parameter int HI_W  = 5
) (
  input  logic [31:0]   insn,
  input  logic [AW-1:0] base,
  output mem_op_e       op,
  output logic [AW-1:0] ea
);
  localparam int LO_W = IMM_W - HI_W;
  localparam int EXT_W = AW - IMM_W;

  logic [OPC_W-1:0] opc;
  logic             is_store;
  logic [IMM_W-1:0] imm_flat;
  logic [IMM_W-1:0] imm_split;
  logic [IMM_W-1:0] imm_sel;

  assign opc = insn[31:32-OPC_W];

  always_comb begin
    case (opc)
      OPC_LINK: op = MOP_LINK;
      OPC_COND: op = MOP_COND;
      OPC_ST_W: op = MOP_ST_W;
      OPC_ST_B: op = MOP_ST_B;
      OPC_ST_H: op = MOP_ST_H;
      default:  op = MOP_NONE;
    endcase
  end

  assign is_store  = (op == MOP_COND) || (op == MOP_ST_W) ||
                     (op == MOP_ST_B) || (op == MOP_ST_H);
  assign imm_flat  = insn[IMM_W-1:0];
  assign imm_split = {insn[25:26-HI_W], insn[LO_W-1:0]};
  assign imm_sel   = is_store ? imm_split : imm_flat;
  assign ea        = base + {{EXT_W{imm_sel[IMM_W-1]}}, imm_sel};

endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int AW        = 32,
  parameter int GRAN_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [AW-1:0] set_addr,
  input  logic [AW-1:0] probe_addr,
  output logic          live,
  output logic          hit_exact,
  output logic          hit_word
);
  logic          live_q, live_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] probe_word;

  assign probe_word = {probe_addr[AW-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
  assign hit_exact  = live_q && (probe_addr == addr_q);
  assign hit_word   = live_q && (probe_word == addr_q);
  assign live       = live_q;

  always_comb begin
    live_d = live_q;
    addr_d = addr_q;
    if (set_en) begin
      live_d = 1'b1;
      addr_d = set_addr;
    end else if (clr_en) begin
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      addr_q <= '0;
    end else if (set_en || clr_en) begin
      live_q <= live_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/llsc_reserve_unit.sv
module llsc_reserve_unit
  import llsc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int IMM_W     = 16,
  parameter int GRAN_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [31:0]   insn,
  input  logic [AW-1:0] base_val,
  input  logic [DW-1:0] store_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cond_flag
);
  mem_op_e       op;
  logic [AW-1:0] ea;
  logic          resv_live, hit_exact, hit_word;
  logic          is_plain_st, is_cond, is_link, known;
  logic          set_en, clr_en;

  llsc_decode #(.AW(AW), .IMM_W(IMM_W), .HI_W(5)) u_dec (
    .insn (insn),
    .base (base_val),
    .op   (op),
    .ea   (ea)
  );

  assign is_link     = op_valid && (op == MOP_LINK);
  assign is_cond     = op_valid && (op == MOP_COND);
  assign is_plain_st = op_valid && ((op == MOP_ST_W) || (op == MOP_ST_B) ||
                                    (op == MOP_ST_H));
  assign known       = op_valid && (op != MOP_NONE);
  assign set_en      = is_link;
  assign clr_en      = is_cond || (is_plain_st && hit_word);

  llsc_resv #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .set_addr   (ea),
    .probe_addr (ea),
    .live       (resv_live),
    .hit_exact  (hit_exact),
    .hit_word   (hit_word)
  );

  logic          we_d, flag_d;
  logic          flag_q, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    we_d   = is_plain_st || (is_cond && hit_exact);
    flag_d = is_cond ? hit_exact : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (known) begin
      addr_q <= ea;
      data_q <= store_data;
    end
  end

  assign mem_we    = we_q;
  assign cond_flag = flag_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

endmodule

// File: rtl/llsc_reserve_unit_chk.sv
module llsc_reserve_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [5:0] insn_opc,
  input logic       mem_we,
  input logic       cond_flag,
  input logic       resv_live
);
  logic       prev_valid;
  logic [5:0] prev_opc;
  logic       prev_flag;
  logic       prev_cond, prev_link, prev_other;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_opc   <= '0;
      prev_flag  <= 1'b0;
    end else begin
      prev_valid <= op_valid;
      prev_opc   <= insn_opc;
      prev_flag  <= cond_flag;
    end
  end

  assign prev_cond  = prev_valid && (prev_opc == 6'h33);
  assign prev_link  = prev_valid && (prev_opc == 6'h1B);
  assign prev_other = prev_valid && !(prev_opc == 6'h1B || prev_opc == 6'h33 ||
                      prev_opc == 6'h35 || prev_opc == 6'h36 || prev_opc == 6'h37);

  assert_we_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> prev_valid);

  assert_flag_only_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_flag != prev_flag) |-> prev_cond);

  assert_cond_write_matches_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prev_cond |-> (mem_we == cond_flag));

  assert_cond_consumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prev_cond |-> !resv_live);

  assert_link_sets_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prev_link |-> resv_live);

  assert_other_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prev_other |-> !mem_we);

endmodule

bind llsc_reserve_unit llsc_reserve_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .insn_opc  (insn[31:26]),
  .mem_we    (mem_we),
  .cond_flag (cond_flag),
  .resv_live (resv_live)
);

// File: tb/sim_llsc_reserve_unit.sv
`timescale 1ns/1ps
module sim_llsc_reserve_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [31:0] insn, base_val, store_data;
  logic        mem_we, cond_flag;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  llsc_reserve_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .insn(insn),
    .base_val(base_val), .store_data(store_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cond_flag(cond_flag)
  );

  function automatic logic [31:0] ld_word(input logic [5:0] opc, input logic [15:0] imm);
    return {opc, 5'd3, 5'd4, imm};
  endfunction

  function automatic logic [31:0] st_word(input logic [5:0] opc, input logic [15:0] imm);
    return {opc, imm[15:11], 5'd4, 5'd7, imm[10:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] b, input logic [31:0] d);
    @(negedge clk);
    insn = w; base_val = b; store_data = d; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_link(input logic [31:0] b, input logic [15:0] imm);
    issue(ld_word(6'h1B, imm), b, 32'h0);
  endtask

  task automatic do_cond(input logic [31:0] b, input logic [15:0] imm, input logic [31:0] d);
    issue(st_word(6'h33, imm), b, d);
  endtask

  task automatic t_reset;
    chk("R1 flag", {31'b0, cond_flag}, 32'd0);
    chk("R1 we", {31'b0, mem_we}, 32'd0);
    do_cond(32'h100, 16'h0, 32'h1111);
    chk("R1 first cond flag", {31'b0, cond_flag}, 32'd0);
    chk("R1 first cond we", {31'b0, mem_we}, 32'd0);
  endtask

  task automatic t_basic_pair;
    do_link(32'h1000, 16'h0010);
    chk("R2 addr", mem_addr, 32'h1010);
    chk("R2 we", {31'b0, mem_we}, 32'd0);
    chk("R10 link keeps flag", {31'b0, cond_flag}, 32'd0);
    do_cond(32'h1000, 16'h0010, 32'hCAFEF00D);
    chk("R3 flag", {31'b0, cond_flag}, 32'd1);
    chk("R3 we", {31'b0, mem_we}, 32'd1);
    chk("R3 addr", mem_addr, 32'h1010);
    chk("R3 data", mem_wdata, 32'hCAFEF00D);
    @(negedge clk);
    chk("R9 we pulse ends", {31'b0, mem_we}, 32'd0);
    do_cond(32'h1000, 16'h0010, 32'h5);
    chk("R5 second cond flag", {31'b0, cond_flag}, 32'd0);
    chk("R5 second cond we", {31'b0, mem_we}, 32'd0);
  endtask

  task automatic t_negative_imm;
    do_link(32'h2000, 16'hFFF8);
    chk("R2 negative addr", mem_addr, 32'h1FF8);
    do_cond(32'h2000, 16'hFFF8, 32'hA5A5A5A5);
    chk("R8 split negative flag", {31'b0, cond_flag}, 32'd1);
    chk("R8 split negative addr", mem_addr, 32'h1FF8);
  endtask

  task automatic t_plain_same_word;
    do_link(32'h3000, 16'h0);
    issue(st_word(6'h36, 16'h0002), 32'h3000, 32'h77);
    chk("R6 byte store we", {31'b0, mem_we}, 32'd1);
    chk("R6 byte store addr", mem_addr, 32'h3002);
    chk("R10 store keeps flag", {31'b0, cond_flag}, 32'd1);
    do_cond(32'h3000, 16'h0, 32'h9);
    chk("R6 cond after byte store", {31'b0, cond_flag}, 32'd0);
    do_link(32'h5000, 16'h0);
    issue(st_word(6'h35, 16'h0), 32'h5000, 32'h1);
    chk("R6 word store we", {31'b0, mem_we}, 32'd1);
    do_cond(32'h5000, 16'h0, 32'h9);
    chk("R6 cond after word store", {31'b0, cond_flag}, 32'd0);
  endtask

  task automatic t_plain_other_word;
    do_link(32'h4000, 16'h0);
    issue(st_word(6'h37, 16'h0004), 32'h4000, 32'h2);
    chk("R7 half store we", {31'b0, mem_we}, 32'd1);
    chk("R7 half store addr", mem_addr, 32'h4004);
    do_cond(32'h4000, 16'h0, 32'h3);
    chk("R7 cond still succeeds", {31'b0, cond_flag}, 32'd1);
  endtask

  task automatic t_idle;
    do_link(32'h6000, 16'h0);
    @(negedge clk);
    insn = st_word(6'h33, 16'h0); base_val = 32'h6000; op_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 idle no write", {31'b0, mem_we}, 32'd0);
    chk("R9 idle flag holds", {31'b0, cond_flag}, 32'd1);
    do_cond(32'h6000, 16'h0, 32'h4);
    chk("R9 reservation held", {31'b0, cond_flag}, 32'd1);
  endtask

  task automatic t_other_opcode;
    do_link(32'h7000, 16'h0);
    issue(st_word(6'h38, 16'h0), 32'h7000, 32'hDEAD);
    chk("R11 no write", {31'b0, mem_we}, 32'd0);
    chk("R11 addr unchanged", mem_addr, 32'h7000);
    do_cond(32'h7000, 16'h0, 32'h4);
    chk("R11 reservation kept", {31'b0, cond_flag}, 32'd1);
  endtask

  task automatic t_replace_and_miss;
    do_link(32'h8000, 16'h0);
    do_link(32'h9000, 16'h0);
    do_cond(32'h8000, 16'h0, 32'h4);
    chk("R12 old address fails", {31'b0, cond_flag}, 32'd0);
    chk("R12 no write", {31'b0, mem_we}, 32'd0);
    do_link(32'hA000, 16'h0);
    do_cond(32'hA000, 16'h0004, 32'h4);
    chk("R4 address miss flag", {31'b0, cond_flag}, 32'd0);
    chk("R4 address miss we", {31'b0, mem_we}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; insn = '0; base_val = '0; store_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_pair();
    t_negative_imm();
    t_plain_same_word();
    t_plain_other_word();
    t_idle();
    t_other_opcode();
    t_replace_and_miss();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule